// File: doc/BRIEF.md
# Trigger Input Conditioner

This block turns one of several raw trigger sources into a clean trigger for a waveform sequencer. The sources are a general-purpose front trigger pin and a bank of backplane trigger lines. A numeric source code picks the source. The chosen signal is resynchronized into the fast system clock and sampled. Sampling happens either on every fast cycle or only at the rising edges of a 10 MHz reference clock. The sampled value then goes through level or edge qualification with a selectable polarity.

The 10 MHz reference is not used as a clock inside the block. It is brought in as a signal, resynchronized, and its rising edges are detected in the fast domain. Each detected edge produces a one-cycle sample strobe. All state therefore lives in one clock domain, and the time of each sample is set by the reference.

The front pin can also serve as a software-controlled digital line. When it is an output, software writes its value and reads the same value back, and the pin cannot act as a trigger. When it is an input, software reads its synchronized level and the pin may drive the trigger.

Top module: `trig_cond`

## Requirements
- R1: A source code of 0 selects the front pin. A code of 4000+k, for 0 <= k < NUM_BP, selects backplane line k. Any other code keeps `trig_out` low, and inputs that are not selected never affect `trig_out`.
- R2: A backplane line is always sampled only at reference rising edges, even when `cfg_sync` is 0.
- R3: Mode code 1 asserts `trig_out` while the sample is high and code 2 while it is low. Code 3 detects a rising edge and code 4 a falling edge. Codes 0, 5, 6 and 7 keep `trig_out` low.
- R4: With `cfg_sync`=0 the front pin is sampled on every fast cycle. A change on the pin reaches `trig_out` at the 4th rising fast-clock edge after the change.
- R5: In an edge mode, each qualifying transition of the sample gives exactly one fast-cycle pulse on `trig_out`. A transition of the wrong polarity gives no pulse.
- R6: With reference sampling, a new input value is taken only at a reference rising edge. The value is taken however long it has been present before that edge. The result appears on `trig_out` at the 4th rising fast-clock edge after the reference rises.
- R7: With `cfg_dir`=0, the front pin is an output:
  - `trig_pin_oe` is 1.
  - `trig_pin_out` and `rd_pin` both equal `sw_out_val`.
  - Source code 0 keeps `trig_out` low.
- R8: With `cfg_dir`=1, `trig_pin_oe` is 0 and `rd_pin` shows the pin level two fast-clock edges after the pin changes.
- R9: While `rst_n` is low, `trig_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock (internal sampling clock) |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ref_clk_in | input | 1 | 10 MHz reference, treated as a sampled signal |
| trig_pin_in | input | 1 | Front trigger pin level from the pad |
| trig_pin_out | output | 1 | Value driven onto the front pin in output direction |
| trig_pin_oe | output | 1 | Output enable for the front pin pad |
| bp_trig_in | input | NUM_BP | Backplane trigger lines |
| cfg_src | input | SRC_W | Source code (0 = front pin, 4000+k = line k) |
| cfg_mode | input | 3 | Activity mode (1 high, 2 low, 3 rise, 4 fall) |
| cfg_sync | input | 1 | Front pin sampling: 0 every fast cycle, 1 reference edges |
| cfg_dir | input | 1 | Pin direction: 0 software output, 1 input |
| sw_out_val | input | 1 | Software-written pin value |
| rd_pin | output | 1 | Software readback of the pin |
| trig_out | output | 1 | Conditioned trigger to the sequencer |

## Verification
Every trigger result is due at the 4th rising fast edge after its cause. With free-running sampling the cause is the input change; with reference sampling it is the reference rising edge. The bench therefore checks the old value after three edges, the new value or pulse after four, and the post-pulse value after five. In reference mode the input is first held for six cycles with no reference edge, to show that nothing is taken early. Readback is checked only after the pin has been stable for far more than its two-edge latency.

// File: rtl/trig_cond_pkg.sv
package trig_cond_pkg;
  localparam int unsigned SRC_FRONT     = 0;
  localparam int unsigned SRC_LINE_BASE = 4000;

  typedef enum logic [2:0] {
    ACT_OFF  = 3'd0,
    ACT_HIGH = 3'd1,
    ACT_LOW  = 3'd2,
    ACT_RISE = 3'd3,
    ACT_FALL = 3'd4
  } act_e;

  function automatic logic act_is_edge(input logic [2:0] m);
    return (m == ACT_RISE) || (m == ACT_FALL);
  endfunction

  function automatic logic act_is_known(input logic [2:0] m);
    return (m >= 3'd1) && (m <= 3'd4);
  endfunction
endpackage

// File: rtl/trig_sync.sv
module trig_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= d;
      stage2_q <= stage1_q;
    end
  end

  assign q = stage2_q;
endmodule

// File: rtl/trig_sampler.sv
module trig_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic use_ref,
  input  logic ref_s,
  input  logic din,
  output logic take_d,
  output logic cur,
  output logic prev
);
  logic take;
  logic ref_prev_q, ref_prev_d;
  logic cur_q, cur_d;
  logic prev_q, prev_d;
  logic take_q, take_nx;

  // sample strobe: every cycle, or one cycle per detected reference rise
  assign take = use_ref ? (ref_s & ~ref_prev_q) : 1'b1;

  always_comb begin
    ref_prev_d = ref_s;
    take_nx    = take;
    cur_d      = cur_q;
    prev_d     = prev_q;
    if (take) begin
      cur_d  = din;
      prev_d = cur_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_prev_q <= 1'b0;
      cur_q      <= 1'b0;
      prev_q     <= 1'b0;
      take_q     <= 1'b0;
    end else begin
      ref_prev_q <= ref_prev_d;
      cur_q      <= cur_d;
      prev_q     <= prev_d;
      take_q     <= take_nx;
    end
  end

  assign take_d = take_q;
  assign cur    = cur_q;
  assign prev   = prev_q;

  AST_REF_TAKE_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    (use_ref && $past(use_ref) && take) |-> !$past(take)); // R6
endmodule

// File: rtl/trig_detect.sv
module trig_detect
  import trig_cond_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] mode,
  input  logic       valid,
  input  logic       take_d,
  input  logic       cur,
  input  logic       prev,
  output logic       trig
);
  logic trig_q, trig_d;

  always_comb begin
    trig_d = 1'b0;
    if (valid) begin
      case (mode)
        ACT_HIGH: trig_d = cur;
        ACT_LOW:  trig_d = ~cur;
        ACT_RISE: trig_d = take_d & cur & ~prev;
        ACT_FALL: trig_d = take_d & ~cur & prev;
        default:  trig_d = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trig_q <= 1'b0;
    else        trig_q <= trig_d;
  end

  assign trig = trig_q;

  AST_BAD_MODE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !act_is_known($past(mode)) |-> !trig_q); // R3
  AST_RISE_NEEDS_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(trig_q) && act_is_edge($past(mode))) |-> $past(take_d)); // R5
endmodule

// File: rtl/trig_cond.sv
module trig_cond
  import trig_cond_pkg::*;
#(
  parameter int NUM_BP = 8,
  parameter int SRC_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_clk_in,
  input  logic              trig_pin_in,
  output logic              trig_pin_out,
  output logic              trig_pin_oe,
  input  logic [NUM_BP-1:0] bp_trig_in,
  input  logic [SRC_W-1:0]  cfg_src,
  input  logic [2:0]        cfg_mode,
  input  logic              cfg_sync,
  input  logic              cfg_dir,
  input  logic              sw_out_val,
  output logic              rd_pin,
  output logic              trig_out
);
  localparam int IDX_W = (NUM_BP > 1) ? $clog2(NUM_BP) : 1;

  // reset: asserted asynchronously, released on the clock
  logic rst_meta_q, rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sn     <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sn     <= rst_meta_q;
    end
  end

  logic              pin_s;
  logic [NUM_BP-1:0] line_s;
  logic              ref_s;

  trig_sync #(.W(1)) u_pin_sync (
    .clk(clk), .rst_n(rst_sn), .d(trig_pin_in), .q(pin_s));
  trig_sync #(.W(NUM_BP)) u_line_sync (
    .clk(clk), .rst_n(rst_sn), .d(bp_trig_in), .q(line_s));
  trig_sync #(.W(1)) u_ref_sync (
    .clk(clk), .rst_n(rst_sn), .d(ref_clk_in), .q(ref_s));

  // source decode
  logic [SRC_W-1:0] line_off;
  logic [IDX_W-1:0] line_idx;
  logic             is_line, is_front, src_valid, use_ref, sel_raw;

  assign line_off  = cfg_src - SRC_W'(SRC_LINE_BASE);
  assign is_line   = (cfg_src >= SRC_W'(SRC_LINE_BASE)) && (line_off < SRC_W'(NUM_BP));
  assign is_front  = (cfg_src == SRC_W'(SRC_FRONT));
  assign line_idx  = line_off[IDX_W-1:0];
  assign src_valid = is_line | (is_front & cfg_dir);
  assign use_ref   = is_line | cfg_sync;
  assign sel_raw   = is_line ? line_s[line_idx] : pin_s;

  logic take_d, cur, prev;

  trig_sampler u_sampler (
    .clk(clk), .rst_n(rst_sn), .use_ref(use_ref), .ref_s(ref_s),
    .din(sel_raw), .take_d(take_d), .cur(cur), .prev(prev));

  trig_detect u_detect (
    .clk(clk), .rst_n(rst_sn), .mode(cfg_mode), .valid(src_valid),
    .take_d(take_d), .cur(cur), .prev(prev), .trig(trig_out));

  // software GPIO view of the pin
  assign trig_pin_oe  = ~cfg_dir;
  assign trig_pin_out = sw_out_val;
  assign rd_pin       = cfg_dir ? pin_s : sw_out_val;

  AST_BAD_SRC_QUIET: assert property (@(posedge clk) disable iff (!rst_sn)
    !$past(src_valid) |-> !trig_out); // R1
  AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_sn)
    ($past(trig_out) && act_is_edge($past(cfg_mode))
     && ($past(cfg_mode, 2) == $past(cfg_mode))
     && ($past(cfg_src, 2) == $past(cfg_src))
     && ($past(cfg_sync, 2) == $past(cfg_sync))) |-> !trig_out); // R5
  AST_RESET_LOW: assert property (@(posedge clk)
    !rst_sn |=> (!rst_sn || !trig_out) ); // R9
endmodule

// File: tb/trig_cond_tb.sv
module trig_cond_tb;
  localparam int NUM_BP = 8;
  localparam int SRC_W  = 16;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n;
  logic ref_clk_in, trig_pin_in, trig_pin_out, trig_pin_oe;
  logic [NUM_BP-1:0] bp_trig_in;
  logic [SRC_W-1:0]  cfg_src;
  logic [2:0]        cfg_mode;
  logic cfg_sync, cfg_dir, sw_out_val, rd_pin, trig_out;

  int checks = 0;
  int errors = 0;

  trig_cond #(.NUM_BP(NUM_BP), .SRC_W(SRC_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .ref_clk_in(ref_clk_in),
    .trig_pin_in(trig_pin_in), .trig_pin_out(trig_pin_out),
    .trig_pin_oe(trig_pin_oe), .bp_trig_in(bp_trig_in),
    .cfg_src(cfg_src), .cfg_mode(cfg_mode), .cfg_sync(cfg_sync),
    .cfg_dir(cfg_dir), .sw_out_val(sw_out_val), .rd_pin(rd_pin),
    .trig_out(trig_out));

  task automatic chk(input string req, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: got %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic lvl_exp(input int m, input logic ok, input logic v);
    if (!ok) return 1'b0;
    if (m == 1) return v;
    if (m == 2) return ~v;
    return 1'b0;
  endfunction

  function automatic logic due_exp(input int m, input logic ok, input logic vo, input logic vn);
    if (!ok) return 1'b0;
    if (m == 3) return vn & ~vo;
    if (m == 4) return ~vn & vo;
    return lvl_exp(m, ok, vn);
  endfunction

  // selected source gets v, every other source gets ~v
  task automatic drive(input int src, input logic v);
    trig_pin_in = (src == 0) ? v : ~v;
    for (int k = 0; k < NUM_BP; k++)
      bp_trig_in[k] = (src == 4000 + k) ? v : ~v;
  endtask

  task automatic ref_pulse();
    ref_clk_in = 1'b1; wait_n(10);
    ref_clk_in = 1'b0; wait_n(10);
  endtask

  task automatic trans(input int src, input int m, input logic ok, input logic use_ref,
                       input string tag, input logic vo, input logic vn);
    drive(src, vn);
    if (use_ref) begin
      wait_n(6);
      chk(tag, trig_out, lvl_exp(m, ok, vo), "held before reference edge");
      ref_clk_in = 1'b1;
    end
    wait_n(3);
    chk(tag, trig_out, lvl_exp(m, ok, vo), "before due edge");
    wait_n(1);
    chk(tag, trig_out, due_exp(m, ok, vo, vn), "at due edge");
    wait_n(1);
    chk(tag, trig_out, lvl_exp(m, ok, vn), "after due edge");
    wait_n(5);
    ref_clk_in = 1'b0;
    wait_n(10);
  endtask

  task automatic run_case(input int dir, input int sy, input int m, input int src);
    logic line, ok, use_ref, sw;
    string tag;
    line    = (src >= 4000) && (src < 4000 + NUM_BP);
    ok      = line || (src == 0 && dir == 1);
    use_ref = line || (sy == 1);
    sw      = 1'((m + src + dir) % 2);
    if (!line && src != 0)            tag = "R1";
    else if (src == 0 && dir == 0)    tag = "R7";
    else if (line && sy == 0)         tag = "R2";
    else if (m < 1 || m > 4)          tag = "R3";
    else if (m == 3 || m == 4)        tag = "R5";
    else if (use_ref)                 tag = "R6";
    else                              tag = "R4";
    cfg_dir = 1'(dir); cfg_sync = 1'(sy); cfg_mode = 3'(m);
    cfg_src = SRC_W'(src); sw_out_val = sw;
    drive(src, 1'b0);
    ref_clk_in = 1'b0;
    wait_n(4);
    ref_pulse();
    ref_pulse();
    if (dir == 0) begin
      chk("R7", trig_pin_oe, 1'b1, "pin oe");
      chk("R7", trig_pin_out, sw, "pin out value");
      chk("R7", rd_pin, sw, "readback of written value");
    end else begin
      chk("R8", trig_pin_oe, 1'b0, "pin oe");
      chk("R8", rd_pin, (src == 0) ? 1'b0 : 1'b1, "readback of pin level");
    end
    trans(src, m, ok, use_ref, tag, 1'b0, 1'b1);
    trans(src, m, ok, use_ref, tag, 1'b1, 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    ref_clk_in = 1'b0; trig_pin_in = 1'b1; bp_trig_in = '1;
    cfg_src = '0; cfg_mode = 3'd2; cfg_sync = 1'b0; cfg_dir = 1'b1; sw_out_val = 1'b0;
    wait_n(5);
    chk("R9", trig_out, 1'b0, "trigger during reset");
    rst_n = 1'b1;
    wait_n(3);
    for (int d = 0; d < 2; d++)
      for (int sy = 0; sy < 2; sy++)
        for (int m = 0; m < 8; m++)
          for (int si = 0; si < 7; si++) begin
            int src;
            case (si)
              0: src = 0;
              1: src = 4000;
              2: src = 4003;
              3: src = 4007;
              4: src = 1;
              5: src = 3999;
              default: src = 4008;
            endcase
            run_case(d, sy, m, src);
          end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule